// File: doc/BRIEF.md
# Port-Width Adaptive Bus Sequencer

This block is a bus master that moves a single operand of one, two, three or four bytes between a core and a 32-bit asynchronous data bus. The slaves on that bus may be 8, 16 or 32 bits wide. The block never knows a slave's width in advance. Each bus cycle asks for every byte still outstanding. The slave ends the cycle with a two-bit active-low acknowledge, and that acknowledge also reports the slave's width. The sequencer takes only the bytes that the reported width and the address alignment allow. It then advances the address, reduces the remaining count and opens another cycle, until the operand is complete.

The core raises a request for one clock while the block is idle. The request carries a byte address, a size code, a direction flag and right-justified write data. While busy, the block ignores any further requests. When the last byte has moved, it pulses `done` and holds the assembled read data, right-justified, on `rdata`. Narrow slaves always sit on the upper byte lanes: a 16-bit port on lines 31..16 and an 8-bit port on lines 31..24. On writes, the outgoing bytes are therefore copied onto lanes so that every port width finds the next byte where it expects it.

Top module: `bus_size_seq`

## Requirements
- R1: After reset, `bus_strobe`, `done` and `busy` are all low.
- R2: While `bus_strobe` is high and `bus_ack_n` is 2'b11, the cycle stays open: strobe stays high, and `bus_addr` and `bus_siz` do not change.
- R3: `bus_ack_n` = 2'b00 ends the cycle as a 32-bit port. An aligned four-byte read then completes in one cycle, with the operand taken from lines 31..0.
- R4: `bus_ack_n` = 2'b01 ends the cycle as a 16-bit port, using lines 31..16. An aligned four-byte read takes two cycles, at addresses A and A+2, with `bus_siz` 2'b00 and then 2'b10.
- R5: `bus_ack_n` = 2'b10 ends the cycle as an 8-bit port, using lines 31..24. An aligned four-byte read takes four cycles, with `bus_siz` 00, 11, 10, 01, and `done` never follows a byte-port acknowledge while more than one byte remains.
- R6: `bus_siz` and `req_size` encode a byte count: 2'b01=1, 2'b10=2, 2'b11=3, 2'b00=4. The first cycle of every request asks for the full operand size.
- R7: Each completed cycle moves min(remaining, W - (address mod W)) bytes, where W is the reported port width in bytes. The bytes come from the lanes that start at the lane given by address mod W, lane 0 being lines 31..24. A misaligned operand therefore takes extra cycles even on a 32-bit port.
- R8: On writes, lane L (lane 0 = lines 31..24) carries outstanding byte L-(addr mod 4) if L >= addr mod 4. Otherwise it carries byte L-(addr mod 2) if L >= addr mod 2. Otherwise it carries byte 0. Byte 0 is the most significant outstanding byte.
- R9: Strobe drops for at least one clock after every acknowledge. `done` is a one-clock pulse in the clock after the final acknowledge, with `rdata` holding the operand right-justified.
- R10: A request raised while `busy` is high is ignored: it changes no bus address and starts no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-clock request strobe from the core |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Operand size code (01=1, 10=2, 11=3, 00=4 bytes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write operand |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Right-justified read operand |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | AW | Address of the current bus cycle |
| bus_siz | output | 2 | Bytes still outstanding, same code as req_size |
| bus_read | output | 1 | 1 = read cycle |
| bus_strobe | output | 1 | Bus cycle open |
| bus_dout | output | 32 | Write lanes |
| bus_din | input | 32 | Read lanes |
| bus_ack_n | input | 2 | Active-low acknowledge and port width (11 wait, 10 byte, 01 half, 00 full) |

## Verification
A wrong remaining count or address shows up in the next bus cycle. The address or size code of that cycle comes out wrong, or the number of cycles before `done` does. The bench logs every cycle's address and size, so the error is caught within one acknowledge. A wrong lane choice for reads corrupts `rdata` at the done pulse, because the slave model fills the lanes a narrow port does not drive with filler bytes. A wrong write lane leaves a wrong byte in the slave's memory, which is checked right after each write.

// File: rtl/bus_size_seq.sv
module bus_size_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic          bus_read,
  output logic          bus_strobe,
  output logic [31:0]   bus_dout,
  input  logic [31:0]   bus_din,
  input  logic [1:0]    bus_ack_n
);

  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [2:0]    rem_q;
  logic          wr_q;
  logic [DW-1:0] wbuf;
  logic [DW-1:0] acc;
  logic          done_q;

  logic          ack_seen;
  logic [2:0]    pw, off, room, nmov, req_bytes;
  logic [5:0]    sh_mov, sh_off, sh_keep, sh_req;
  logic [DW-1:0] got;

  assign ack_seen = (st == S_RUN) && (bus_ack_n != 2'b11);

  always_comb begin
    case (bus_ack_n)
      2'b10:   pw = 3'd1;
      2'b01:   pw = 3'd2;
      default: pw = 3'd4;
    endcase
  end

  assign off       = (pw == 3'd4) ? {1'b0, addr_q[1:0]} :
                     (pw == 3'd2) ? {2'b00, addr_q[0]} : 3'd0;
  assign room      = pw - off;
  assign nmov      = (rem_q < room) ? rem_q : room;
  assign sh_mov    = {nmov, 3'b000};
  assign sh_off    = {off, 3'b000};
  assign sh_keep   = {3'd4 - nmov, 3'b000};
  assign got       = (bus_din << sh_off) >> sh_keep;
  assign req_bytes = (req_size == 2'b00) ? 3'd4 : {1'b0, req_size};
  assign sh_req    = {3'd4 - req_bytes, 3'b000};

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [1:0] sel;
    always_comb begin
      if (2'(l) >= addr_q[1:0])
        sel = 2'(l) - addr_q[1:0];
      else if (2'(l) >= {1'b0, addr_q[0]})
        sel = 2'(l) - {1'b0, addr_q[0]};
      else
        sel = 2'd0;
    end
    assign bus_dout[DW-1-8*l -: 8] = wbuf[(DW-1) - 8*int'(sel) -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      rem_q  <= 3'd0;
      wr_q   <= 1'b0;
      wbuf   <= '0;
      acc    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem_q  <= req_bytes;
          wr_q   <= req_write;
          wbuf   <= req_wdata << sh_req;
          acc    <= '0;
          st     <= S_RUN;
        end
        S_RUN: if (ack_seen) begin
          addr_q <= addr_q + AW'(nmov);
          rem_q  <= rem_q - nmov;
          wbuf   <= wbuf << sh_mov;
          acc    <= (acc << sh_mov) | got;
          if (rem_q == nmov) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP:   st <= S_RUN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign rdata      = acc;
  assign busy       = (st != S_IDLE);
  assign bus_addr   = addr_q;
  assign bus_siz    = rem_q[1:0];
  assign bus_read   = !wr_q;
  assign bus_strobe = (st == S_RUN);

endmodule

module bus_size_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_strobe,
  input logic [1:0]    bus_ack_n,
  input logic [1:0]    bus_siz,
  input logic [AW-1:0] bus_addr,
  input logic          done
);

  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack_n == 2'b11) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_siz)));

  a_r9_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack_n != 2'b11) |=> !bus_strobe);

  a_r9_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_strobe && bus_ack_n != 2'b11));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_byte_port_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack_n == 2'b10 && bus_siz != 2'b01) |=> !done);

endmodule

bind bus_size_seq bus_size_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_ack_n(bus_ack_n),
  .bus_siz(bus_siz), .bus_addr(bus_addr), .done(done)
);

// File: tb/sim_bus_size_seq.sv
module sim_bus_size_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        done, busy, bus_read, bus_strobe;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [1:0]  bus_siz;
  logic [31:0] bus_din = 32'hEEEEEEEE;
  logic [1:0]  bus_ack_n = 2'b11;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [0:15];
  logic [31:0] log_addr [0:7];
  logic [1:0]  log_siz [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_size_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .busy(busy), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_read(bus_read), .bus_strobe(bus_strobe),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
  endtask

  function automatic logic [31:0] slave_din(input logic [31:0] a, input int port);
    logic [31:0] d;
    int base;
    d = 32'hEEEEEEEE;
    base = int'(a[3:0]) & ~(port - 1);
    for (int l = 0; l < port; l++) d[31-8*l -: 8] = mem[base + l];
    return d;
  endfunction

  task automatic slave_write(input logic [31:0] a, input logic [1:0] sz, input int port);
    int rem, off, n;
    rem = (sz == 2'b00) ? 4 : int'(sz);
    off = int'(a[3:0]) % port;
    n = (rem < port - off) ? rem : port - off;
    for (int j = 0; j < n; j++) mem[int'(a[3:0]) + j] = bus_dout[31-8*(off+j) -: 8];
  endtask

  function automatic logic [1:0] ack_code(input int port);
    return (port == 1) ? 2'b10 : (port == 2) ? 2'b01 : 2'b00;
  endfunction

  task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                      input logic [31:0] wd, input int port, input int waits,
                      input bit poke, output logic [31:0] rd, output int ncyc);
    int wcnt;
    bit got_done;
    logic [31:0] sa;
    logic [1:0] ss;
    wcnt = 0; ncyc = 0; got_done = 0; rd = '0; sa = '0; ss = '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      req_valid = 1'b0;
      if (done) begin rd = rdata; got_done = 1; break; end
      if (bus_strobe) begin
        if (wcnt == 0) begin sa = bus_addr; ss = bus_siz; end
        else chk(bus_addr == sa && bus_siz == ss, "R2", "held during wait", bus_addr, sa);
        if (poke && wcnt == 1) begin
          req_valid = 1'b1; req_addr = 32'h0000000C; req_size = 2'b01;
        end
        if (wcnt < waits) wcnt++;
        else begin
          if (ncyc < 8) begin log_addr[ncyc] = bus_addr; log_siz[ncyc] = bus_siz; end
          ncyc++;
          bus_ack_n = ack_code(port);
          bus_din = slave_din(bus_addr, port);
          if (wr) slave_write(bus_addr, bus_siz, port);
          @(negedge clk);
          req_valid = 1'b0;
          bus_ack_n = 2'b11;
          bus_din = 32'hEEEEEEEE;
          chk(!bus_strobe, "R9", "strobe low after ack", 32'(bus_strobe), 32'd0);
          wcnt = 0;
          continue;
        end
      end
      @(negedge clk);
    end
    chk(got_done, "R9", "done seen", 32'(got_done), 32'd1);
    @(negedge clk);
    chk(!done, "R9", "done one clock", 32'(done), 32'd0);
  endtask

  function automatic logic [31:0] exp_read(input int a, input int n);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'(mem[a + i]);
    return v;
  endfunction

  task automatic t_reset();
    chk(!bus_strobe && !done && !busy, "R1", "idle after reset",
        {29'd0, bus_strobe, done, busy}, 32'd0);
  endtask

  task automatic t_long_full();
    logic [31:0] rd; int n;
    mem_init();
    xfer(32'd0, 2'b00, 1'b0, '0, 4, 2, 1'b0, rd, n);
    chk(rd == exp_read(0, 4), "R3", "full port data", rd, exp_read(0, 4));
    chk(n == 1, "R3", "one cycle", 32'(n), 32'd1);
    chk(log_siz[0] == 2'b00, "R6", "first size full", 32'(log_siz[0]), 32'd0);
  endtask

  task automatic t_long_half();
    logic [31:0] rd; int n;
    mem_init();
    xfer(32'd4, 2'b00, 1'b0, '0, 2, 1, 1'b0, rd, n);
    chk(rd == exp_read(4, 4), "R4", "half port data", rd, exp_read(4, 4));
    chk(n == 2, "R4", "two cycles", 32'(n), 32'd2);
    chk(log_addr[1] == 32'd6 && log_siz[1] == 2'b10, "R4", "second cycle addr/size",
        {log_addr[1][29:0], log_siz[1]}, {30'd6, 2'b10});
  endtask

  task automatic t_long_byte();
    logic [31:0] rd; int n;
    mem_init();
    xfer(32'd8, 2'b00, 1'b0, '0, 1, 0, 1'b0, rd, n);
    chk(rd == exp_read(8, 4), "R5", "byte port data", rd, exp_read(8, 4));
    chk(n == 4, "R5", "four cycles", 32'(n), 32'd4);
    chk({log_siz[0], log_siz[1], log_siz[2], log_siz[3]} == 8'b00_11_10_01, "R5",
        "size sequence", 32'({log_siz[0], log_siz[1], log_siz[2], log_siz[3]}), 32'h39);
  endtask

  task automatic t_misaligned();
    logic [31:0] rd; int n;
    mem_init();
    xfer(32'd1, 2'b00, 1'b0, '0, 4, 0, 1'b0, rd, n);
    chk(rd == exp_read(1, 4), "R7", "misaligned long data", rd, exp_read(1, 4));
    chk(n == 2 && log_addr[1] == 32'd4 && log_siz[1] == 2'b01, "R7", "3+1 split",
        32'(n), 32'd2);
    xfer(32'd3, 2'b10, 1'b0, '0, 2, 0, 1'b0, rd, n);
    chk(rd == exp_read(3, 2), "R7", "odd word on half port", rd, exp_read(3, 2));
    chk(n == 2, "R7", "odd word cycles", 32'(n), 32'd2);
    xfer(32'd6, 2'b01, 1'b0, '0, 4, 0, 1'b0, rd, n);
    chk(rd == exp_read(6, 1) && n == 1 && log_siz[0] == 2'b01, "R6", "byte operand",
        rd, exp_read(6, 1));
  endtask

  task automatic check_written(input int a, input int nb, input logic [31:0] wd, input string what);
    for (int i = 0; i < nb; i++)
      chk(mem[a + i] == wd[8*(nb-1-i) +: 8], "R8", what, 32'(mem[a + i]), 32'(wd[8*(nb-1-i) +: 8]));
  endtask

  task automatic t_writes();
    logic [31:0] rd; int n;
    mem_init();
    xfer(32'd1, 2'b00, 1'b1, 32'h11223344, 1, 0, 1'b0, rd, n);
    check_written(1, 4, 32'h11223344, "long to byte port");
    mem_init();
    xfer(32'd2, 2'b10, 1'b1, 32'h0000BEEF, 2, 1, 1'b0, rd, n);
    check_written(2, 2, 32'h0000BEEF, "word to half port");
    mem_init();
    xfer(32'd3, 2'b00, 1'b1, 32'hCAFEF00D, 4, 0, 1'b0, rd, n);
    check_written(3, 4, 32'hCAFEF00D, "long to full port");
    chk(n == 2, "R8", "misaligned write cycles", 32'(n), 32'd2);
    mem_init();
    xfer(32'd5, 2'b11, 1'b1, 32'h00778899, 2, 0, 1'b0, rd, n);
    check_written(5, 3, 32'h00778899, "three bytes to half port");
  endtask

  task automatic t_busy_ignore();
    logic [31:0] rd; int n; bit extra;
    mem_init();
    xfer(32'd4, 2'b10, 1'b0, '0, 4, 3, 1'b1, rd, n);
    chk(n == 1 && log_addr[0] == 32'd4, "R10", "request while busy ignored", log_addr[0], 32'd4);
    extra = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bus_strobe || busy) extra = 1;
    end
    chk(!extra, "R10", "no extra cycle", 32'(extra), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem_init();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_full();
    t_long_half();
    t_long_byte();
    t_misaligned();
    t_writes();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule